// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a shared data bus. The bus is modelled as a separate input, output and output-enable. Each command carries the address, the direction, the byte-lane write enables and the selects. The block captures the command on a rising clock edge. The matching data transfer takes place on the second rising edge after the command, whether it is a read or a write. Because both directions use the same spacing, a bus master can issue reads and writes in any mix on consecutive cycles with no idle cycles between them. The bus floats during the data phase of a write, a deselect or an empty slot.

A command can start a short burst instead of a single access. While the load/advance control stays high after an accepted command, the block generates the next address of a four-beat group by itself and keeps the direction of the command that opened the group. A static input picks the beat order: linear wrap or XOR-interleaved. A stall input freezes the whole pipeline, including the command stages, the read register and any pending write. This shifts every data phase later by the length of the stall. An asynchronous output-enable and a sleep input can each force the bus off. Sleep also refuses new commands. The array keeps its contents in both cases.

Top module: `zbt_sram`

## Requirements
- R1: For a write command accepted at edge E, the block stores `data_in` sampled at edge E+2. Only the byte lanes whose `be` bit was set in the command change (bit b controls data bits [8b+7:8b]); the other lanes keep their old value.
- R2: For a read command accepted at edge E, `data_oe` is high between edge E+1 and edge E+2, and `data_out` holds the stored word during that interval.
- R3: A read issued on the cycle right after a write to the same address returns the merged new word, with no idle cycle between the two commands.
- R4: A new command is accepted only when `adv` is low and all three selects are active (`sel0_n`=0, `sel1`=1, `sel2_n`=0). With any select inactive, no access starts, but commands already in the pipeline still complete.
- R5: `data_oe` is low in the data phase of a write, of a deselect and of any cycle in which no command was accepted.
- R6: While `stall` is high, all synchronous inputs are ignored and every register holds its value. A stall of N cycles between a command and its data phase delays the data phase by exactly N cycles.
- R7: With `adv` high after an accepted command, the block issues the next beat of a four-beat group. Address bits above bit 1 stay as in the opening command. Beat i (i = 1, 2, 3, then wrapping to 0) gets low bits (start+i) mod 4 when `order_lin`=1, and start XOR i when `order_lin`=0. The beat uses the opening command's direction and the current `be`.
- R8: With `adv` high when no group is active (after reset, a deselect or a sleep cycle), no access starts.
- R9: `out_en_n` high forces `data_oe` low at once, without waiting for a clock edge.
- R10: While `sleep` is high, no command is accepted, any open burst group ends, and `data_oe` is low. The stored words are kept.
- R11: After synchronous reset, the pipeline is empty and `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High freezes the whole pipeline |
| sel0_n | input | 1 | Select, active low |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| we | input | 1 | Direction of a new command: 1 write, 0 read |
| adv | input | 1 | 0 loads a new command, 1 advances the burst group |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| be | input | NB (2) | Byte-lane write enables |
| addr | input | AW (4) | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Blocks commands and floats the bus |
| data_in | input | NB*LW (16) | Bus data seen by the block |
| data_out | output | NB*LW (16) | Bus data driven by the block |
| data_oe | output | 1 | High when the block drives the bus |

## Verification
The bench first writes and reads every word with full-lane writes, then sweeps partial-lane writes to separate lane merging from whole-word stores. Strictly alternating write/read pairs to one address, with changing lane masks, show whether the early read picks up the write that commits on the same edge. Stalls placed before a read's data phase and inside a write's data phase, with junk on the bus, measure the delay and show whether stalled data is ignored. Bursts in both orders, each from a start that is not aligned to the group, together with deselect, idle-advance, sleep and output-enable cases, show whether a blocked command left any trace by reading those words back afterwards.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BURST_BEATS = 4;
    localparam int BIDX_W      = $clog2(BURST_BEATS);

    typedef enum logic {
        ORD_XOR    = 1'b0,
        ORD_LINEAR = 1'b1
    } burst_ord_e;

    // low address bits of beat idx in a group opened at start
    function automatic logic [BIDX_W-1:0] beat_lo(
        input logic [BIDX_W-1:0] start,
        input logic [BIDX_W-1:0] idx,
        input burst_ord_e        ord
    );
        if (ord == ORD_LINEAR) return start + idx;
        return start ^ idx;
    endfunction

    function automatic logic all_selected(
        input logic s0_n,
        input logic s1,
        input logic s2_n
    );
        return !s0_n && s1 && !s2_n;
    endfunction

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              sleep,
    input  logic              adv,
    input  logic              we,
    input  logic              sel_ok,
    input  logic              order_lin,
    input  logic [AW-1:0]     addr,
    input  logic [NB-1:0]     be,
    output logic [AW+NB+1:0]  cmd_o
);
    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } cmd_t;

    logic              act_q;
    logic [AW-1:0]     base_q;
    logic [BIDX_W-1:0] idx_q;
    logic              dir_q;
    logic              load, cont;
    logic [BIDX_W-1:0] idx_nx;
    cmd_t              cmd;

    always_comb begin
        load   = !sleep && !adv && sel_ok;
        cont   = !sleep && adv && act_q;
        idx_nx = idx_q + 1'b1;
        cmd    = '0;
        if (load) begin
            cmd.valid = 1'b1;
            cmd.wr    = we;
            cmd.addr  = addr;
            cmd.be    = be;
        end else if (cont) begin
            cmd.valid = 1'b1;
            cmd.wr    = dir_q;
            cmd.addr  = base_q;
            cmd.addr[BIDX_W-1:0] = beat_lo(base_q[BIDX_W-1:0], idx_nx,
                                           burst_ord_e'(order_lin));
            cmd.be    = be;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            dir_q  <= 1'b0;
        end else if (!stall) begin
            if (load) begin
                act_q  <= 1'b1;
                base_q <= addr;
                idx_q  <= '0;
                dir_q  <= we;
            end else if (cont) begin
                idx_q  <= idx_nx;
            end else begin
                act_q  <= 1'b0;
            end
        end
    end

    assign cmd_o = cmd;

    // R7: an accepted command opens or keeps a group with its direction
    assert_group_dir_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall && cmd.valid) |=> (act_q && dir_q == $past(cmd.wr)));

    // R8: a cycle that issues nothing leaves no group to advance
    assert_idle_closes_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall && !cmd.valid) |=> !act_q);

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic [AW+NB+1:0] cmd_i,
    output logic             s1_valid,
    output logic             s1_wr,
    output logic [AW-1:0]    s1_addr,
    output logic [AW+NB+1:0] s2_o
);
    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } cmd_t;

    cmd_t s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (!stall) begin
            s1_q <= cmd_t'(cmd_i);
            s2_q <= s1_q;
        end
    end

    assign s1_valid = s1_q.valid;
    assign s1_wr    = s1_q.wr;
    assign s1_addr  = s1_q.addr;
    assign s2_o     = s2_q;

    // R6: a stalled cycle moves nothing down the pipeline
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(s1_q) && $stable(s2_q)));

    // R4: an accepted command always reaches its commit stage
    assert_pending_done_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall && s1_q.valid) |=> s2_q.valid);

endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
    parameter int AW = 4,
    parameter int NB = 2,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             rd_valid,
    input  logic             rd_wr,
    input  logic [AW-1:0]    rd_addr,
    input  logic [AW+NB+1:0] wr_cmd,
    input  logic [NB*LW-1:0] din,
    output logic [NB*LW-1:0] rdata,
    output logic             drive
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * LW;

    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } cmd_t;

    cmd_t          wc;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rdata_q;
    logic          drive_q;
    logic          commit, hit;

    assign wc = cmd_t'(wr_cmd);

    always_comb begin
        commit = !stall && wc.valid && wc.wr;
        hit    = wc.valid && wc.wr && (wc.addr == rd_addr);
        for (int b = 0; b < NB; b++) begin
            rd_word[b*LW +: LW] = (hit && wc.be[b]) ? din[b*LW +: LW]
                                                    : mem[rd_addr][b*LW +: LW];
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int b = 0; b < NB; b++) begin
                if (wc.be[b]) mem[wc.addr][b*LW +: LW] <= din[b*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            drive_q <= 1'b0;
        end else if (!stall) begin
            rdata_q <= rd_word;
            drive_q <= rd_valid && !rd_wr;
        end
    end

    assign rdata = rdata_q;
    assign drive = drive_q;

    // R2: a read one stage before its data phase turns the driver on
    assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && rd_valid && !rd_wr) |=> drive_q);

    // R5: write, deselect or empty slot leaves the driver off
    assert_write_floats_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall && !(rd_valid && !rd_wr)) |=> !drive_q);

    // R3: a full-lane write committing on the read edge is forwarded
    assert_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (!stall && rd_valid && !rd_wr && hit && (&wc.be)) |=> (rdata_q == $past(din)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             we,
    input  logic             adv,
    input  logic             order_lin,
    input  logic [NB-1:0]    be,
    input  logic [AW-1:0]    addr,
    input  logic             out_en_n,
    input  logic             sleep,
    input  logic [NB*LW-1:0] data_in,
    output logic [NB*LW-1:0] data_out,
    output logic             data_oe
);
    localparam int CW = AW + NB + 2;

    logic          sel_ok;
    logic [CW-1:0] cmd;
    logic          s1_valid, s1_wr;
    logic [AW-1:0] s1_addr;
    logic [CW-1:0] s2;
    logic          drive;

    assign sel_ok = all_selected(sel0_n, sel1, sel2_n);

    zbt_issue #(.AW(AW), .NB(NB)) u_issue (
        .clk(clk), .rst(rst), .stall(stall), .sleep(sleep), .adv(adv),
        .we(we), .sel_ok(sel_ok), .order_lin(order_lin),
        .addr(addr), .be(be), .cmd_o(cmd)
    );

    zbt_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk(clk), .rst(rst), .stall(stall), .cmd_i(cmd),
        .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_addr(s1_addr), .s2_o(s2)
    );

    zbt_store #(.AW(AW), .NB(NB), .LW(LW)) u_store (
        .clk(clk), .rst(rst), .stall(stall),
        .rd_valid(s1_valid), .rd_wr(s1_wr), .rd_addr(s1_addr),
        .wr_cmd(s2), .din(data_in), .rdata(data_out), .drive(drive)
    );

    assign data_oe = drive && !out_en_n && !sleep;

    // R4: incomplete select with a load request starts nothing
    assert_desel_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall && !adv && !sel_ok) |=> !s1_valid);

    // R10: sleep refuses commands
    assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (!stall && sleep) |=> !s1_valid);

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int LW = 8;
    localparam int DW = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    logic stall, sel0_n, sel1, sel2_n, we, adv, order_lin, out_en_n, sleep;
    logic [NB-1:0] be;
    logic [AW-1:0] addr;
    logic [DW-1:0] data_in, data_out;
    logic data_oe;

    zbt_sram #(.AW(AW), .NB(NB), .LW(LW)) uut (
        .clk(clk), .rst(rst), .stall(stall), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .we(we), .adv(adv), .order_lin(order_lin), .be(be),
        .addr(addr), .out_en_n(out_en_n), .sleep(sleep), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R11";

    // stimulus for the next step
    logic t_stall, t_we, t_adv, t_ord, t_oen, t_sleep;
    int t_desel;
    int t_addr;
    logic [NB-1:0] t_be;
    logic [DW-1:0] t_wd;

    // reference model
    logic [DW-1:0] ref_mem [DEPTH];
    logic ph_v, ph_wr, p1_v, p1_wr;
    int ph_a, p1_a;
    logic [NB-1:0] ph_be, p1_be;
    logic [DW-1:0] ph_wd, p1_wd, ph_exp;
    logic b_act, b_dir;
    int b_base, b_idx;
    logic seen_oe;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step();
        logic exp_oe, load, cont, nv, nwr;
        int na, lo;
        @(negedge clk);
        stall = t_stall; we = t_we; adv = t_adv; order_lin = t_ord;
        out_en_n = t_oen; sleep = t_sleep; be = t_be; addr = AW'(t_addr);
        sel0_n = (t_desel == 1); sel1 = (t_desel != 2); sel2_n = (t_desel == 3);
        data_in = (ph_v && ph_wr && !t_stall) ? ph_wd : (16'hBAD0 ^ DW'(cyc));
        #1;
        exp_oe = ph_v && !ph_wr && !t_oen && !t_sleep;
        seen_oe = data_oe;
        chk({31'd0, data_oe}, {31'd0, exp_oe}, "data_oe");
        if (exp_oe) chk({16'd0, data_out}, {16'd0, ph_exp}, "data_out");
        @(posedge clk);
        if (!t_stall) begin
            if (ph_v && ph_wr)
                for (int b = 0; b < NB; b++)
                    if (ph_be[b]) ref_mem[ph_a][b*LW +: LW] = ph_wd[b*LW +: LW];
            ph_v = p1_v; ph_wr = p1_wr; ph_a = p1_a; ph_be = p1_be; ph_wd = p1_wd;
            ph_exp = ref_mem[p1_a];
            load = !t_sleep && !t_adv && (t_desel == 0);
            cont = !t_sleep && t_adv && b_act;
            nv = 0; nwr = 0; na = 0;
            if (load) begin
                nv = 1; nwr = t_we; na = t_addr;
                b_act = 1; b_base = t_addr; b_idx = 0; b_dir = t_we;
            end else if (cont) begin
                b_idx = (b_idx + 1) % 4;
                lo = t_ord ? ((b_base % 4) + b_idx) % 4 : ((b_base % 4) ^ b_idx);
                nv = 1; nwr = b_dir; na = (b_base / 4) * 4 + lo;
            end else begin
                b_act = 0;
            end
            p1_v = nv; p1_wr = nwr; p1_a = na; p1_be = t_be; p1_wd = t_wd;
        end
    endtask

    task automatic defaults();
        t_stall = 0; t_we = 0; t_adv = 0; t_ord = 1; t_oen = 0; t_sleep = 0;
        t_desel = 1; t_addr = 0; t_be = '1; t_wd = '0;
    endtask

    task automatic issue(input logic wr, input int a, input logic [NB-1:0] m, input logic [DW-1:0] wd);
        defaults(); t_desel = 0; t_we = wr; t_addr = a; t_be = m; t_wd = wd;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin defaults(); step(); end
    endtask

    task automatic beat(input logic [DW-1:0] wd, input logic ord);
        defaults(); t_adv = 1; t_ord = ord; t_wd = wd; step();
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a + 1) * 16'h1357) ^ DW'(salt * 16'h0F31) ^ 16'h9C00;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ph_v = 0; ph_wr = 0; ph_a = 0; ph_be = '0; ph_wd = '0; ph_exp = '0;
        p1_v = 0; p1_wr = 0; p1_a = 0; p1_be = '0; p1_wd = '0;
        b_act = 0; b_dir = 0; b_base = 0; b_idx = 0; seen_oe = 0;
        defaults();
        stall = 0; we = 0; adv = 0; order_lin = 1; out_en_n = 0; sleep = 0;
        be = '0; addr = '0; sel0_n = 1; sel1 = 1; sel2_n = 0; data_in = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R11";
        chk({31'd0, data_oe}, 32'd0, "data_oe in reset");
        rst = 0;
        idle(2);

        // R1/R2: full sweep write then read
        tag = "R1";
        for (int a = 0; a < DEPTH; a++) issue(1, a, 2'b11, pat(a, 0));
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) issue(0, a, 2'b11, '0);
        idle(2);

        // R1: byte-lane merge sweep
        tag = "R1";
        for (int a = 0; a < 4; a++)
            for (int m = 1; m < 3; m++) issue(1, a, 2'(m), pat(a, m + 7));
        for (int a = 0; a < 4; a++) issue(0, a, 2'b00, '0);
        idle(2);

        // R3: strictly alternating write/read, no idle cycles
        tag = "R3";
        for (int i = 0; i < DEPTH; i++) begin
            issue(1, i, 2'(i % 3 + 1), pat(i, 20 + i));
            issue(0, i, 2'b00, '0);
        end
        for (int i = 0; i < 8; i++) begin
            issue(0, (i + 3) % DEPTH, 2'b00, '0);
            issue(1, (i + 3) % DEPTH, 2'b11, pat(i, 40));
            issue(0, (i + 3) % DEPTH, 2'b00, '0);
        end
        idle(2);

        // R4: deselects ignore new commands; pending read completes
        tag = "R4";
        issue(0, 9, 2'b00, '0);
        for (int d = 1; d < 4; d++) begin
            defaults(); t_desel = d; t_we = 1; t_addr = 9 + d; t_wd = 16'hFFFF; step();
        end
        idle(1);
        for (int d = 0; d < 4; d++) issue(0, 9 + d, 2'b00, '0);
        idle(2);

        // R5: write and deselect phases float the bus between reads
        tag = "R5";
        issue(0, 1, 2'b00, '0);
        issue(1, 2, 2'b11, pat(2, 50));
        idle(1);
        issue(0, 2, 2'b00, '0);
        issue(1, 1, 2'b01, pat(1, 51));
        issue(0, 1, 2'b00, '0);
        idle(2);

        // R6: stall delays a read's data phase by exactly its length
        tag = "R6";
        begin
            int first;
            first = -1;
            issue(0, 5, 2'b00, '0);
            for (int k = 1; k <= 8; k++) begin
                defaults(); t_stall = (k <= 3); step();
                if (seen_oe && first < 0) first = k;
            end
            chk(32'(first), 32'd5, "first data phase step after 3-cycle stall");
        end
        // stall inside a write's data phase: junk on the bus is ignored
        issue(1, 6, 2'b11, pat(6, 60));
        idle(1);
        defaults(); t_stall = 1; step();
        defaults(); t_stall = 1; step();
        idle(1);
        issue(0, 6, 2'b00, '0);
        defaults(); t_stall = 1; step();
        idle(3);

        // R7: linear write group from 6, then interleaved read group from 5
        tag = "R7";
        issue(1, 6, 2'b11, pat(6, 70));
        for (int i = 1; i < 4; i++) beat(pat(i, 71), 1'b1);
        idle(2);
        for (int a = 4; a < 8; a++) issue(0, a, 2'b00, '0);
        issue(1, 13, 2'b11, pat(13, 72));
        for (int i = 1; i < 5; i++) beat(pat(i, 73), 1'b0);
        idle(1);
        issue(0, 5, 2'b00, '0);
        for (int i = 1; i < 4; i++) beat('0, 1'b0);
        for (int a = 12; a < 16; a++) issue(0, a, 2'b00, '0);
        idle(2);

        // R8: advance with no open group does nothing
        tag = "R8";
        idle(1);
        for (int i = 0; i < 3; i++) beat(16'h5555, 1'b1);
        issue(0, 0, 2'b00, '0);
        issue(0, 1, 2'b00, '0);
        idle(2);

        // R9: output enable forces the bus off at once
        tag = "R9";
        issue(0, 3, 2'b00, '0);
        idle(1);
        defaults(); t_oen = 1; step();
        issue(0, 4, 2'b00, '0);
        idle(1);
        defaults(); t_oen = 0; step();
        idle(1);

        // R10: sleep blocks commands and bursts, floats bus, keeps data
        tag = "R10";
        issue(0, 7, 2'b00, '0);
        idle(1);
        defaults(); t_sleep = 1; t_desel = 0; t_we = 1; t_addr = 7; t_wd = 16'h0; step();
        issue(1, 8, 2'b11, pat(8, 80));
        defaults(); t_sleep = 1; t_adv = 1; t_wd = 16'h1111; step();
        beat(16'h2222, 1'b1);
        idle(1);
        for (int a = 7; a < 12; a++) issue(0, a, 2'b00, '0);
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule